// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Selectable Decay

This block produces the four gate commands for one full bridge. The bridge has two legs, A and B, and each leg has a high-side switch and a low-side switch. A current chopper supplies an on/off command, and the surrounding logic supplies the current direction, a bridge enable and a decay-mode select. From these inputs the block decides which switches conduct.

During the on time the block drives one diagonal of the bridge. During the off time it lets the winding current recirculate in one of two ways:

- **Fast decay.** Only the low side that parallels the freewheeling diode is used, for quasi-synchronous rectification.
- **Slow decay.** Both high sides are used, for synchronous recirculation.

Each leg is sequenced on its own. A switch may turn on only after both switches of its leg have been off for a programmable dead time, counted in clock cycles. A switch turns off on the next clock edge, with no wait. The gate outputs are registered. The dead time is set by `DEAD_CYC`, and its default of 200 cycles gives 1 µs at a 200 MHz clock.

Top module: `hbridge_gate_seq`

## Requirements
- R1: The high and low gates of the same leg are never both 1 in any cycle.
- R2: With `enable`=1 and `chop_on`=1, `phase`=1 selects gates A-high and B-low. `phase`=0 selects B-high and A-low.
- R3: Fast decay applies when `slow_decay`=0 and `chop_on`=0. Both switches of the conducting diagonal turn off on the first edge. After `DEAD_CYC` all-off cycles in that leg, only one low side turns on: A-low for `phase`=1, or B-low for `phase`=0. The other high side stays off.
- R4: Slow decay applies when `slow_decay`=1 and `chop_on`=0. Only the conducting low side turns off on the first edge. After `DEAD_CYC` cycles, the high side of that leg turns on, so both high gates are 1.
- R5: When the off time ends, a switch turns on only after its leg has been fully off for `DEAD_CYC` consecutive cycles. A leg that has already been idle that long turns on at the next edge.
- R6: A `phase` change during the on time turns all four gates off for exactly `DEAD_CYC` cycles. After that, the new diagonal turns on.
- R7: A 0 on `enable` sampled at an edge makes all four gates 0 after that edge, whatever the other inputs are.
- R8: Reset gives all four gates 0. Both legs count as idle, so the first on command is applied at the first edge after reset.
- R9: For any sequence of input changes, each leg follows the per-leg rule. Turn-off happens at once, a change between high and low passes through the dead time, and an unchanged target holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Bridge enable; 0 turns off all switches |
| phase | input | 1 | Current direction: 1 = A-high/B-low diagonal |
| chop_on | input | 1 | Chopper command: 1 = on time, 0 = off time |
| slow_decay | input | 1 | Decay select: 0 = fast, 1 = slow |
| gate_a_hi | output | 1 | Leg A high-side gate |
| gate_a_lo | output | 1 | Leg A low-side gate |
| gate_b_hi | output | 1 | Leg B high-side gate |
| gate_b_lo | output | 1 | Leg B low-side gate |

## Verification
The hardest situation to reach is an input change that arrives while a leg is still partway through its dead time. In that case the leg's target changes again before the leg turns on, and an early or late turn-on would break the cross-conduction guarantee. A directed sequence first walks through on, fast-off, slow-off, phase reversal and enable-off, with fixed expected patterns. A sweep then moves between every ordered pair of the 16 input combinations, holding each combination just past the dead time. This drives every leg through each from/to target pair, and a per-leg arithmetic reference gives the expected gates in every cycle.

// File: rtl/gsq_pkg.sv
// Shared types for the full-bridge gate sequencer.
package gsq_pkg;
    // Target or current conduction of one leg.
    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_e;
endpackage

// File: rtl/gsq_target.sv
// Decodes the bridge command into a conduction target for each leg.
// Assumes: legs are indexed 0 = A and 1 = B.
// The off-time targets depend on which diagonal was conducting, which phase identifies.
module gsq_target
    import gsq_pkg::*;
(
    input  logic enable,
    input  logic phase,
    input  logic chop_on,
    input  logic slow_decay,
    output leg_e tgt_a,
    output leg_e tgt_b
);
    // Purpose: choose the leg targets for enable, on time, fast decay and slow decay.
    always_comb begin
        if (!enable) begin
            tgt_a = LEG_OFF;
            tgt_b = LEG_OFF;
        end else if (chop_on) begin
            tgt_a = phase ? LEG_HI : LEG_LO;
            tgt_b = phase ? LEG_LO : LEG_HI;
        end else if (slow_decay) begin
            tgt_a = LEG_HI;
            tgt_b = LEG_HI;
        end else begin
            tgt_a = phase ? LEG_LO  : LEG_OFF;
            tgt_b = phase ? LEG_OFF : LEG_LO;
        end
    end
endmodule

// File: rtl/gsq_leg.sv
// Sequences one bridge leg towards its target.
// Turn-off is immediate. Turn-on waits until the leg has been fully off for
// DEAD_CYC consecutive cycles. Assumes DEAD_CYC >= 1.
module gsq_leg
    import gsq_pkg::*;
#(
    parameter int DEAD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  leg_e tgt,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_W = CW'(DEAD_CYC);
    localparam logic [CW-1:0] ONE_W  = CW'(1);

    leg_e          cur;
    logic [CW-1:0] idle_cnt;

    // Purpose: leg state and off-time counter; the reset state counts as idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= LEG_OFF;
            idle_cnt <= DEAD_W;
        end else if (cur != LEG_OFF && tgt != cur) begin
            cur      <= LEG_OFF;
            idle_cnt <= ONE_W;
        end else if (cur == LEG_OFF) begin
            if (tgt != LEG_OFF && idle_cnt >= DEAD_W)
                cur <= tgt;
            else if (idle_cnt < DEAD_W)
                idle_cnt <= idle_cnt + ONE_W;
        end
    end

    assign gate_hi = (cur == LEG_HI);
    assign gate_lo = (cur == LEG_LO);

    // Checker counter, kept separate from the sequencer: consecutive cycles with both gates low.
    logic [CW-1:0] chk_off;

    // Purpose: measure the all-off run that precedes each turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_off <= DEAD_W;
        else if (gate_hi || gate_lo)
            chk_off <= '0;
        else if (chk_off < DEAD_W)
            chk_off <= chk_off + ONE_W;
    end

    // R1: a leg never conducts through both switches at once.
    p_leg_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R5: any turn-on is preceded by at least DEAD_CYC all-off cycles.
    p_dead_before_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi || gate_lo) |-> chk_off >= DEAD_W);
endmodule

// File: rtl/hbridge_gate_seq.sv
// Gate-drive sequencer for one full bridge: decodes the command into leg
// targets and runs one dead-time sequencer per leg.
// Assumes the inputs are synchronous to clk and DEAD_CYC >= 1.
module hbridge_gate_seq
    import gsq_pkg::*;
#(
    parameter int DEAD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic phase,
    input  logic chop_on,
    input  logic slow_decay,
    output logic gate_a_hi,
    output logic gate_a_lo,
    output logic gate_b_hi,
    output logic gate_b_lo
);
    localparam int NLEG = 2;

    leg_e            tgt [NLEG];
    logic [NLEG-1:0] hi;
    logic [NLEG-1:0] lo;

    gsq_target u_target (
        .enable     (enable),
        .phase      (phase),
        .chop_on    (chop_on),
        .slow_decay (slow_decay),
        .tgt_a      (tgt[0]),
        .tgt_b      (tgt[1])
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        gsq_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .tgt     (tgt[g]),
            .gate_hi (hi[g]),
            .gate_lo (lo[g])
        );
    end

    assign gate_a_hi = hi[0];
    assign gate_a_lo = lo[0];
    assign gate_b_hi = hi[1];
    assign gate_b_lo = lo[1];

    // R7: an enable sampled low leaves every gate off after that edge.
    p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo));

    // R6: the A-high/B-low diagonal never hands over directly to the other diagonal.
    p_no_direct_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_a_hi && gate_b_lo) |-> !(gate_a_lo || gate_b_hi));

    // R6: the reverse hand-over is blocked too.
    p_no_direct_swap_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_b_hi && gate_a_lo) |-> !(gate_b_lo || gate_a_hi));
endmodule

// File: tb/hbridge_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hbridge_gate_seq_tb_top;
    localparam int D = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, phase = 1'b0, chop_on = 1'b0, slow_decay = 1'b0;
    logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    // Reference state per leg: 0 off, 1 high, 2 low; oc = off cycles (saturating at D).
    int m_st [2];
    int m_oc [2];

    always #2.5 clk = ~clk;

    hbridge_gate_seq #(.DEAD_CYC(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .phase(phase),
        .chop_on(chop_on), .slow_decay(slow_decay),
        .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
        .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo)
    );

    function automatic logic [3:0] gates();
        return {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        n_run++;
        if (gates() !== exp) begin
            n_fail++;
            $display("FAIL %s: gates(ahi,alo,bhi,blo) got %b expected %b", tag, gates(), exp);
        end
    endtask

    // One clock edge, then check at the falling edge.
    task automatic cyc(input logic [3:0] exp, input string tag);
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic hold(input int n, input logic [3:0] exp, input string tag);
        for (int i = 0; i < n; i++) cyc(exp, tag);
    endtask

    // Leg targets from the requirements: code 0 off, 1 high, 2 low.
    function automatic int tgt_of(input int leg);
        if (!enable) return 0;
        if (chop_on) return (phase ^ (leg == 1)) ? 1 : 2;
        if (slow_decay) return 1;
        return (phase ^ (leg == 1)) ? 2 : 0;
    endfunction

    task automatic model_reset();
        for (int l = 0; l < 2; l++) begin m_st[l] = 0; m_oc[l] = D; end
    endtask

    task automatic model_edge();
        for (int l = 0; l < 2; l++) begin
            int t = tgt_of(l);
            if (m_st[l] != 0 && t != m_st[l]) begin
                m_st[l] = 0; m_oc[l] = 1;
            end else if (m_st[l] == 0) begin
                if (t != 0 && m_oc[l] >= D) m_st[l] = t;
                else if (m_oc[l] < D) m_oc[l] = m_oc[l] + 1;
            end
        end
    endtask

    // R9: sweep step checked against the per-leg reference.
    task automatic sweep_cyc();
        logic [3:0] exp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp = {m_st[0] == 1, m_st[0] == 2, m_st[1] == 1, m_st[1] == 2};
        n_run++;
        if ((gate_a_hi && gate_a_lo) || (gate_b_hi && gate_b_lo)) begin
            n_fail++;
            $display("FAIL R1: leg shoot-through got %b expected no leg 11", gates());
        end
        check(exp, "R9");
    endtask

    task automatic apply(input logic [3:0] v);
        {enable, phase, chop_on, slow_decay} = v;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(4'b0000, "R8");
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R8: idle legs turn on at the first edge after reset; R2 diagonal for phase 1.
        apply(4'b1110);
        cyc(4'b1001, "R8");
        hold(2, 4'b1001, "R2");
        // R3: fast decay, phase 1.
        chop_on = 1'b0;
        hold(D, 4'b0000, "R3");
        hold(3, 4'b0100, "R3");
        // R5: end of off time; B-low immediate, A-high after dead time.
        chop_on = 1'b1;
        hold(D, 4'b0001, "R5");
        cyc(4'b1001, "R5");
        // R4: slow decay, phase 1.
        slow_decay = 1'b1; chop_on = 1'b0;
        hold(D, 4'b1000, "R4");
        hold(2, 4'b1010, "R4");
        // R2: on time, phase 0, entered from slow decay.
        phase = 1'b0; chop_on = 1'b1;
        hold(D, 4'b0010, "R2");
        hold(2, 4'b0110, "R2");
        // R6: phase reversal while on.
        phase = 1'b1;
        hold(D, 4'b0000, "R6");
        hold(2, 4'b1001, "R6");
        // R7: enable low overrides all other inputs.
        enable = 1'b0;
        cyc(4'b0000, "R7");
        slow_decay = 1'b0; chop_on = 1'b0;
        hold(D + 2, 4'b0000, "R7");
        // R5: legs idle long enough, so turn-on is immediate.
        enable = 1'b1; chop_on = 1'b1; phase = 1'b0;
        cyc(4'b0110, "R5");
        // R3: fast decay, phase 0, uses only B-low.
        chop_on = 1'b0;
        hold(D, 4'b0000, "R3");
        hold(2, 4'b0001, "R3");

        // R9: sweep over every ordered pair of input combinations.
        do_reset();
        model_reset();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(4'(a));
                for (int k = 0; k < D + 2; k++) sweep_cyc();
                apply(4'(b));
                for (int k = 0; k < D + 2; k++) sweep_cyc();
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule